// File: doc/BRIEF.md
# Wake-up Capable Serial Receiver

This block recovers characters from an asynchronous non-return-to-zero serial line. The line rests high. A character is framed by a low start bit and a high stop bit, and carries 8 or 9 data bits, least significant bit first. The block runs on the system clock and uses a sample enable that pulses sixteen times per bit period. Each completed character is placed in a parallel holding register. Five status flags report on it: character available, line went idle, overrun, noise and framing error.

For multi-drop buses the receiver has a sleep mode. The host sets the sleep bit once the leading address character(s) show that a message is meant for another node. While the bit is set, no status flag can become set and idle detection is switched off, so the rest of the unwanted message never reaches the host. Hardware clears the bit by one of two selectable methods. In idle-line mode it clears when the line has stayed high for a full character time after activity. In address-mark mode it clears when a character arrives with its top data bit set, and that character is then delivered as normal.

Top module: `wake_serial_rx`

## Requirements
- R1: A start bit is accepted only after the line was high and then goes low, and only if at least two of the samples taken at sample ticks 3, 5 and 7 of the bit are low. A low pulse shorter than three ticks produces no character.
- R2: With nine_bit_i = 0 the block takes 8 data bits and with nine_bit_i = 1 it takes 9, least significant bit first. On completion data_o holds the character with bit 8 forced to 0 in 8-bit mode, and full_o goes to 1.
- R3: Each data bit and the stop bit is the 2-of-3 majority of the samples at ticks 7, 8 and 9. If any such sample triple, or the start triple, disagrees, noise_o is set together with the character.
- R4: ferr_o is set together with the character when the stop-bit majority is low. A break, meaning the line held low for at least a whole frame, gives exactly one character of all zeros with ferr_o = 1. No further character starts until the line has gone high again.
- R5: If a character completes while full_o is still 1, ovr_o is set and data_o, noise_o and ferr_o keep the earlier character.
- R6: A one-cycle rd_i pulse clears full_o, ovr_o, noise_o, ferr_o and idle_o on the next clock edge, unless a character is loaded in that same cycle.
- R7: idle_o is set once the line has been continuously high for 10 bit times (8-bit mode) or 11 bit times (9-bit mode) after a confirmed start bit. It is never set without such earlier activity.
- R8: While sleep_o = 1, none of full_o, idle_o, ovr_o, noise_o and ferr_o can become set, and idle detection raises no flag.
- R9: In address-mark mode (wake_addr_i = 1) a character whose top data bit is set (bit 7 in 8-bit mode, bit 8 in 9-bit mode) clears sleep_o and is loaded and flagged as normal. A character with that bit clear is dropped and leaves sleep_o at 1.
- R10: In idle-line mode (wake_addr_i = 0) a full character time of ones after activity clears sleep_o, and that same event does not set idle_o. In address-mark mode idle time leaves sleep_o unchanged.
- R11: sleep_set_i sets sleep_o and sleep_clr_i clears it. When both are asserted in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample enable, 16 pulses per bit period |
| rxd_i | input | 1 | Serial line input, idle high |
| nine_bit_i | input | 1 | 1 = 9 data bits, 0 = 8 data bits |
| wake_addr_i | input | 1 | Wake method: 1 = address mark, 0 = idle line |
| sleep_set_i | input | 1 | Host request to enter sleep |
| sleep_clr_i | input | 1 | Host request to leave sleep |
| rd_i | input | 1 | Host read of the data register, clears the flags |
| data_o | output | 9 | Received character |
| full_o | output | 1 | Character available |
| idle_o | output | 1 | Idle line detected |
| ovr_o | output | 1 | Overrun |
| noise_o | output | 1 | Noise seen in the character |
| ferr_o | output | 1 | Framing error |
| sleep_o | output | 1 | Sleep (wake-up) mode active |

## Verification
The assertions assume the host does not assert sleep_set_i in the same cycle that an address-marked character wakes the receiver. They also assume nine_bit_i and wake_addr_i stay constant while a frame is in flight. The stimulus changes mode inputs only while the line rests high, and pulses host controls only between frames. It holds the sample enable at one pulse per clock, so every bit lasts exactly sixteen cycles. Glitches are limited to one cycle near the bit centre, or to two cycles at a start edge, so their effect on the sample triples is known in advance.

// File: rtl/wurx_pkg.sv
package wurx_pkg;
  typedef enum logic [1:0] {RX_HUNT, RX_START, RX_DATA, RX_STOP} rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic split3(input logic a, input logic b, input logic c);
    return !((a == b) && (b == c));
  endfunction
endpackage

// File: rtl/wurx_sync.sv
module wurx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= '1;
        else         pipe_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= '1;
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/wurx_frame.sv
module wurx_frame
  import wurx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rx_i,
  input  logic          nine_i,
  output logic          start_o,
  output logic          done_o,
  output logic [DW-1:0] char_o,
  output logic          fe_o,
  output logic          nf_o
);
  localparam int PW  = $clog2(OSR);
  localparam int BW  = $clog2(DW);
  localparam int MID = OSR / 2;
  localparam logic [PW-1:0] S_A  = PW'(MID - 5);
  localparam logic [PW-1:0] S_B  = PW'(MID - 3);
  localparam logic [PW-1:0] S_C  = PW'(MID - 1);
  localparam logic [PW-1:0] D_A  = PW'(MID - 1);
  localparam logic [PW-1:0] D_B  = PW'(MID);
  localparam logic [PW-1:0] D_C  = PW'(MID + 1);
  localparam logic [PW-1:0] LAST = PW'(OSR - 1);

  rx_state_e     state_q;
  logic [PW-1:0] phase_q;
  logic [BW-1:0] bit_q;
  logic [DW-1:0] shreg_q;
  logic [1:0]    smp_q;
  logic          noise_q, line_hi_q, nine_q;
  logic          done_q, fe_q, nf_q, start_q;
  logic [BW-1:0] last_bit;
  logic [PW-1:0] phase_nx;
  logic          vote, odd;

  assign last_bit = nine_q ? BW'(DW - 1) : BW'(DW - 2);
  assign phase_nx = (phase_q == LAST) ? '0 : phase_q + 1'b1;
  assign vote     = maj3(smp_q[0], smp_q[1], rx_i);
  assign odd      = split3(smp_q[0], smp_q[1], rx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RX_HUNT;
      phase_q   <= '0;
      bit_q     <= '0;
      shreg_q   <= '0;
      smp_q     <= '0;
      noise_q   <= 1'b0;
      line_hi_q <= 1'b1;
      nine_q    <= 1'b0;
      done_q    <= 1'b0;
      fe_q      <= 1'b0;
      nf_q      <= 1'b0;
      start_q   <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      start_q <= 1'b0;
      if (tick_i) begin
        line_hi_q <= rx_i;
        case (state_q)
          RX_HUNT: begin
            // falling edge after a high sample
            if (!rx_i && line_hi_q) begin
              state_q <= RX_START;
              phase_q <= PW'(1);
              noise_q <= 1'b0;
              nine_q  <= nine_i;
            end
          end
          RX_START: begin
            phase_q <= phase_nx;
            if (phase_q == S_A) smp_q[0] <= rx_i;
            if (phase_q == S_B) smp_q[1] <= rx_i;
            if (phase_q == S_C) begin
              if (vote) state_q <= RX_HUNT;
              else begin
                noise_q <= odd;
                start_q <= 1'b1;
              end
            end
            if (phase_q == LAST) begin
              state_q <= RX_DATA;
              bit_q   <= '0;
            end
          end
          RX_DATA: begin
            phase_q <= phase_nx;
            if (phase_q == D_A) smp_q[0] <= rx_i;
            if (phase_q == D_B) smp_q[1] <= rx_i;
            if (phase_q == D_C) begin
              shreg_q <= {vote, shreg_q[DW-1:1]};
              noise_q <= noise_q | odd;
            end
            if (phase_q == LAST) begin
              if (bit_q == last_bit) state_q <= RX_STOP;
              else                   bit_q   <= bit_q + 1'b1;
            end
          end
          RX_STOP: begin
            phase_q <= phase_nx;
            if (phase_q == D_A) smp_q[0] <= rx_i;
            if (phase_q == D_B) smp_q[1] <= rx_i;
            if (phase_q == D_C) begin
              done_q  <= 1'b1;
              fe_q    <= !vote;
              nf_q    <= noise_q | odd;
              state_q <= RX_HUNT;
            end
          end
          default: state_q <= RX_HUNT;
        endcase
      end
    end
  end

  assign start_o = start_q;
  assign done_o  = done_q;
  assign fe_o    = fe_q;
  assign nf_o    = nf_q;
  assign char_o  = nine_q ? shreg_q : {1'b0, shreg_q[DW-1:1]};
endmodule

// File: rtl/wurx_idle.sv
module wurx_idle #(
  parameter int OSR = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rx_i,
  input  logic nine_i,
  input  logic start_i,
  output logic evt_o
);
  localparam int LIM8 = 10 * OSR;
  localparam int LIM9 = 11 * OSR;
  localparam int CW   = $clog2(LIM9 + 1);

  logic [CW-1:0] cnt_q, lim;
  logic          armed_q, evt_q;

  assign lim = nine_i ? CW'(LIM9) : CW'(LIM8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (start_i) armed_q <= 1'b1;
      if (tick_i) begin
        if (!rx_i)            cnt_q <= '0;
        else if (cnt_q < lim) cnt_q <= cnt_q + 1'b1;
        // one event per quiet period, only after activity
        if (rx_i && armed_q && (cnt_q == lim - 1'b1)) begin
          evt_q   <= 1'b1;
          armed_q <= 1'b0;
        end
      end
    end
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/wurx_status.sv
module wurx_status #(
  parameter int DW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic [DW-1:0] char_i,
  input  logic          fe_i,
  input  logic          nf_i,
  input  logic          idle_evt_i,
  input  logic          nine_i,
  input  logic          wake_addr_i,
  input  logic          rd_i,
  input  logic          sleep_set_i,
  input  logic          sleep_clr_i,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          idle_o,
  output logic          ovr_o,
  output logic          noise_o,
  output logic          ferr_o,
  output logic          sleep_o
);
  logic [DW-1:0] data_q;
  logic full_q, idle_q, ovr_q, nf_q, fe_q, sleep_q;
  logic msb, still_full, wake_mark, wake_quiet, accept;

  assign msb        = nine_i ? char_i[DW-1] : char_i[DW-2];
  assign still_full = full_q & ~rd_i;
  assign wake_mark  = sleep_q & wake_addr_i & done_i & msb;
  assign wake_quiet = sleep_q & ~wake_addr_i & idle_evt_i;
  assign accept     = done_i & (~sleep_q | wake_mark);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      full_q  <= 1'b0;
      idle_q  <= 1'b0;
      ovr_q   <= 1'b0;
      nf_q    <= 1'b0;
      fe_q    <= 1'b0;
      sleep_q <= 1'b0;
    end else begin
      if (rd_i) begin
        full_q <= 1'b0;
        ovr_q  <= 1'b0;
        nf_q   <= 1'b0;
        fe_q   <= 1'b0;
        idle_q <= 1'b0;
      end
      if (accept) begin
        if (still_full) ovr_q <= 1'b1;
        else begin
          data_q <= char_i;
          full_q <= 1'b1;
          fe_q   <= fe_i;
          nf_q   <= nf_i;
        end
      end
      if (idle_evt_i && !sleep_q) idle_q <= 1'b1;
      if (sleep_set_i) sleep_q <= 1'b1;
      else if (sleep_clr_i || wake_mark || wake_quiet) sleep_q <= 1'b0;
    end
  end

  assign data_o  = data_q;
  assign full_o  = full_q;
  assign idle_o  = idle_q;
  assign ovr_o   = ovr_q;
  assign noise_o = nf_q;
  assign ferr_o  = fe_q;
  assign sleep_o = sleep_q;
endmodule

// File: rtl/wake_serial_rx.sv
module wake_serial_rx #(
  parameter int OSR         = 16,
  parameter int DW          = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rxd_i,
  input  logic          nine_bit_i,
  input  logic          wake_addr_i,
  input  logic          sleep_set_i,
  input  logic          sleep_clr_i,
  input  logic          rd_i,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          idle_o,
  output logic          ovr_o,
  output logic          noise_o,
  output logic          ferr_o,
  output logic          sleep_o
);
  logic          rx_s;
  logic          frm_start, frm_done, frm_fe, frm_nf, idle_evt;
  logic [DW-1:0] frm_char;

  wurx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rx_s)
  );

  wurx_frame #(.OSR(OSR), .DW(DW)) u_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .rx_i   (rx_s),
    .nine_i (nine_bit_i),
    .start_o(frm_start),
    .done_o (frm_done),
    .char_o (frm_char),
    .fe_o   (frm_fe),
    .nf_o   (frm_nf)
  );

  wurx_idle #(.OSR(OSR)) u_idle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .rx_i   (rx_s),
    .nine_i (nine_bit_i),
    .start_i(frm_start),
    .evt_o  (idle_evt)
  );

  wurx_status #(.DW(DW)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (frm_done),
    .char_i     (frm_char),
    .fe_i       (frm_fe),
    .nf_i       (frm_nf),
    .idle_evt_i (idle_evt),
    .nine_i     (nine_bit_i),
    .wake_addr_i(wake_addr_i),
    .rd_i       (rd_i),
    .sleep_set_i(sleep_set_i),
    .sleep_clr_i(sleep_clr_i),
    .data_o     (data_o),
    .full_o     (full_o),
    .idle_o     (idle_o),
    .ovr_o      (ovr_o),
    .noise_o    (noise_o),
    .ferr_o     (ferr_o),
    .sleep_o    (sleep_o)
  );
endmodule

// File: rtl/wurx_checker.sv
module wurx_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic rd_i,
  input logic done_i,
  input logic idle_evt_i,
  input logic wake_addr_i,
  input logic sleep_clr_i,
  input logic full_o,
  input logic idle_o,
  input logic ovr_o,
  input logic noise_o,
  input logic ferr_o,
  input logic sleep_o
);
  AST_SLEEP_NO_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> (!$past(sleep_o) || (!sleep_o && $past(wake_addr_i)))); // R8

  AST_SLEEP_NO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_o) |-> !$past(sleep_o)); // R8

  AST_OVR_ON_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> ($past(full_o) && full_o)); // R5

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !done_i) |=> (!full_o && !ovr_o && !noise_o && !ferr_o)); // R6

  AST_ERR_WITH_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ferr_o || noise_o) |-> full_o); // R4

  AST_SLEEP_EXIT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_o) |-> ($past(sleep_clr_i) || $past(done_i) || $past(idle_evt_i))); // R11
endmodule

bind wake_serial_rx wurx_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_i       (rd_i),
  .done_i     (frm_done),
  .idle_evt_i (idle_evt),
  .wake_addr_i(wake_addr_i),
  .sleep_clr_i(sleep_clr_i),
  .full_o     (full_o),
  .idle_o     (idle_o),
  .ovr_o      (ovr_o),
  .noise_o    (noise_o),
  .ferr_o     (ferr_o),
  .sleep_o    (sleep_o)
);

// File: tb/tb_wake_serial_rx.sv
module tb_wake_serial_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       rxd = 1'b1;
  logic       nine = 1'b0;
  logic       wake_addr = 1'b0;
  logic       s_set = 1'b0;
  logic       s_clr = 1'b0;
  logic       rd = 1'b0;
  logic [8:0] data;
  logic       full, idle, ovr, noise, ferr, sleep;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  wake_serial_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd),
    .nine_bit_i(nine), .wake_addr_i(wake_addr), .sleep_set_i(s_set),
    .sleep_clr_i(s_clr), .rd_i(rd), .data_o(data), .full_o(full),
    .idle_o(idle), .ovr_o(ovr), .noise_o(noise), .ferr_o(ferr), .sleep_o(sleep)
  );

  // {stop_level, nine_bit, data[8:0]}
  localparam logic [10:0] VEC [8] = '{
    {1'b1, 1'b0, 9'h055}, {1'b1, 1'b0, 9'h0A3}, {1'b1, 1'b0, 9'h000},
    {1'b1, 1'b0, 9'h0FF}, {1'b1, 1'b1, 9'h1C7}, {1'b1, 1'b1, 9'h0AA},
    {1'b0, 1'b0, 9'h03C}, {1'b0, 1'b1, 9'h131}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic v);
    rxd = v;
    wait_cyc(16);
  endtask

  // glitch_at: data bit index given a one-cycle flip at offset 9, -1 for none
  task automatic send(input logic [8:0] d, input logic nb, input logic stop, input int glitch_at);
    put_bit(1'b0);
    for (int i = 0; i < (nb ? 9 : 8); i++) begin
      if (i == glitch_at) begin
        rxd = d[i]; wait_cyc(9);
        rxd = ~d[i]; wait_cyc(1);
        rxd = d[i]; wait_cyc(6);
      end else put_bit(d[i]);
    end
    put_bit(stop);
    rxd = 1'b1;
  endtask

  task automatic read_pulse();
    rd = 1'b1; wait_cyc(1); rd = 1'b0; wait_cyc(1);
  endtask

  task automatic pulse_set();
    s_set = 1'b1; wait_cyc(1); s_set = 1'b0; wait_cyc(1);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    // reset state
    check("R6 reset flags", {full, idle, ovr, noise, ferr, sleep}, 6'b0);
    wait_cyc(300);
    check("R7 no idle without activity", idle, 1'b0);

    // table walk: R2 data/width, R4 stop level
    foreach (VEC[k]) begin
      logic [8:0] ed;
      nine = VEC[k][9];
      wait_cyc(2);
      send(VEC[k][8:0], VEC[k][9], VEC[k][10], -1);
      wait_cyc(4);
      ed = VEC[k][9] ? VEC[k][8:0] : {1'b0, VEC[k][7:0]};
      check("R2 R4 vector", {full, ferr, noise, ovr, 3'b0, data},
            {1'b1, ~VEC[k][10], 1'b0, 1'b0, 3'b0, ed});
      read_pulse();
      check("R6 read clears", {full, ferr, noise}, 3'b0);
    end
    nine = 1'b0;
    wait_cyc(250);
    read_pulse();

    // R1: short low pulse is not a start
    rxd = 1'b0; wait_cyc(2); rxd = 1'b1;
    wait_cyc(250);
    check("R1 false start rejected", {full, ferr}, 2'b0);

    // R3: glitch inside a data bit
    send(9'h05A, 1'b0, 1'b1, 2);
    wait_cyc(4);
    check("R3 majority keeps data, noise set", {full, noise, data}, {2'b11, 9'h05A});
    read_pulse();
    wait_cyc(250);
    read_pulse();

    // R7: idle flag timing
    send(9'h012, 1'b0, 1'b1, -1);
    wait_cyc(4);
    check("R7 idle not yet", idle, 1'b0);
    wait_cyc(200);
    check("R7 idle after char time", idle, 1'b1);
    read_pulse();
    check("R6 read clears idle", {idle, full}, 2'b0);

    // R5: overrun
    send(9'h061, 1'b0, 1'b1, -1);
    send(9'h062, 1'b0, 1'b1, -1);
    wait_cyc(4);
    check("R5 overrun keeps first", {full, ovr, data}, {2'b11, 9'h061});
    read_pulse();
    check("R6 read clears overrun", {full, ovr}, 2'b00);
    wait_cyc(250);
    read_pulse();

    // R4: break
    rxd = 1'b0; wait_cyc(176); rxd = 1'b1;
    wait_cyc(20);
    check("R4 break frame", {full, ferr, data}, {2'b11, 9'h000});
    read_pulse();
    wait_cyc(250);
    check("R4 single char per break", full, 1'b0);
    read_pulse();

    // R11: host control
    pulse_set();
    check("R11 set", sleep, 1'b1);
    s_clr = 1'b1; wait_cyc(1); s_clr = 1'b0; wait_cyc(1);
    check("R11 clear", sleep, 1'b0);
    s_set = 1'b1; s_clr = 1'b1; wait_cyc(1); s_set = 1'b0; s_clr = 1'b0; wait_cyc(1);
    check("R11 set wins", sleep, 1'b1);
    s_clr = 1'b1; wait_cyc(1); s_clr = 1'b0; wait_cyc(1);

    // R9 and R8: address-mark wake, 8-bit
    wake_addr = 1'b1;
    pulse_set();
    send(9'h012, 1'b0, 1'b1, -1);
    wait_cyc(4);
    check("R8 sleeping drops char", {full, sleep}, 2'b01);
    wait_cyc(200);
    check("R10 R8 address mode ignores idle", {idle, sleep}, 2'b01);
    send(9'h085, 1'b0, 1'b1, -1);
    wait_cyc(4);
    check("R9 address char wakes", {sleep, full, data}, {2'b01, 9'h085});
    wait_cyc(250);
    read_pulse();

    // R9: 9-bit mode uses bit 8 as the mark
    nine = 1'b1;
    wait_cyc(2);
    pulse_set();
    send(9'h0FF, 1'b1, 1'b1, -1);
    wait_cyc(4);
    check("R9 bit7 no wake in 9-bit", {sleep, full}, 2'b10);
    send(9'h101, 1'b1, 1'b1, -1);
    wait_cyc(4);
    check("R9 bit8 wakes", {sleep, full, data}, {2'b01, 9'h101});
    wait_cyc(250);
    read_pulse();
    nine = 1'b0;
    wait_cyc(2);

    // R8: sleep blocks overrun and framing error
    send(9'h011, 1'b0, 1'b1, -1);
    wait_cyc(4);
    pulse_set();
    send(9'h022, 1'b0, 1'b0, -1);
    wait_cyc(4);
    check("R8 no overrun or ferr in sleep", {full, ovr, ferr, data}, {3'b100, 9'h011});
    s_clr = 1'b1; wait_cyc(1); s_clr = 1'b0;
    wait_cyc(250);
    read_pulse();

    // R10: idle-line wake
    wake_addr = 1'b0;
    pulse_set();
    send(9'h033, 1'b0, 1'b1, -1);
    wait_cyc(4);
    check("R10 still asleep after char", {sleep, full}, 2'b10);
    wait_cyc(200);
    check("R10 idle wakes, idle flag held", {sleep, idle, full}, 3'b000);
    send(9'h044, 1'b0, 1'b1, -1);
    wait_cyc(4);
    check("R10 next char delivered", {full, data}, {1'b1, 9'h044});
    read_pulse();

    finish_run();
  end
endmodule